// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic core of a small multicycle processor datapath. A 2-bit mode from the main controller tells it how to treat the current cycle. Address arithmetic for loads and stores always adds, and the equality test for conditional branches always subtracts. Register-to-register instructions hand the choice of operation to the low four bits of the instruction's function field. A restricted register mode recognises only subtraction and signed set-less-than. Any code the decoder does not recognise falls back to addition, so the result is always defined.

The block is purely combinational. Its operands, its mode and its function code go in, and a 32-bit result and a zero flag come out in the same cycle. There is no handshake and no storage, because the surrounding multicycle sequencer latches the result into its own holding register. An overflow pin is provided so the port list matches the datapath, and it is held low.

Top module: `alu_unit`

## Requirements
- R1: With mode 2'b00 the result is opnd_a + opnd_b modulo 2^32, whatever the function code.
- R2: With mode 2'b01 the result is opnd_a - opnd_b modulo 2^32, whatever the function code.
- R3: With mode 2'b10 the low four bits of func_code select the operation: 4'b0000 add, 4'b0010 subtract, 4'b0100 bitwise AND, 4'b0101 bitwise OR, 4'b1010 set-less-than.
- R4: With mode 2'b11 only func_code low bits 4'b0010 (subtract) and 4'b1010 (set-less-than) are recognised. Every other value gives the sum.
- R5: With mode 2'b10, any low-bit value outside the five listed in R3 gives the sum.
- R6: Set-less-than compares the operands as two's-complement signed values. It yields 32'd1 when opnd_a is less than opnd_b and 32'd0 otherwise.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: ovf is always 0.
- R9: func_code bits 5 and 4 never affect result or zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Operation class from the main controller |
| func_code | input | 6 | Function field of the instruction; only the low four bits are decoded |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Overflow indication, tied low |

## Verification
The bench sweeps every mode against all 64 function codes, and then applies seeded random operands and modes against a reference model. This catches a decoder that reads the upper function bits or maps a code to the wrong operation. It also catches a restricted mode that wrongly accepts AND or OR, which would show up as a bitwise result where the sum is expected. Directed cases set operands of opposite sign for set-less-than, where an unsigned compare gives the inverted answer. They also add values that wrap to exactly zero, which checks that the zero flag follows the truncated 32-bit result and not a carry. Equal operands in branch mode confirm that the zero flag rises when the difference is zero.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    MODE_ADDR   = 2'b00,
    MODE_CMP    = 2'b01,
    MODE_REG    = 2'b10,
    MODE_REGLIM = 2'b11
  } alu_mode_e;

  localparam logic [SEL_W-1:0] FN_ADD = 4'b0000;
  localparam logic [SEL_W-1:0] FN_SUB = 4'b0010;
  localparam logic [SEL_W-1:0] FN_AND = 4'b0100;
  localparam logic [SEL_W-1:0] FN_OR  = 4'b0101;
  localparam logic [SEL_W-1:0] FN_SLT = 4'b1010;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] fn_low,
  output alu_op_e          op
);

  alu_op_e reg_op;
  alu_op_e lim_op;

  // full register-mode table, unknown codes fall back to add
  always_comb begin
    unique case (fn_low)
      FN_SUB:  reg_op = OP_SUB;
      FN_AND:  reg_op = OP_AND;
      FN_OR:   reg_op = OP_OR;
      FN_SLT:  reg_op = OP_SLT;
      default: reg_op = OP_ADD;
    endcase
  end

  // restricted register mode: subtract and compare only
  always_comb begin
    unique case (fn_low)
      FN_SUB:  lim_op = OP_SUB;
      FN_SLT:  lim_op = OP_SLT;
      default: lim_op = OP_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_mode_e'(mode))
      MODE_ADDR:   op = OP_ADD;
      MODE_CMP:    op = OP_SUB;
      MODE_REG:    op = reg_op;
      MODE_REGLIM: op = lim_op;
      default:     op = OP_ADD;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         res_zero
);

  localparam int MSB = W - 1;

  logic         invert;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         signed_lt;

  // one shared adder for add, subtract and compare
  assign invert = (op == OP_SUB) || (op == OP_SLT);
  assign b_eff  = invert ? ~b : b;
  assign sum    = a + b_eff + {{(W-1){1'b0}}, invert};

  // differing signs decide directly; otherwise the difference sign does
  assign signed_lt = (a[MSB] ^ b[MSB]) ? a[MSB] : sum[MSB];

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_SLT:  res = {{(W-1){1'b0}}, signed_lt};
      default: res = sum;
    endcase
  end

  assign res_zero = ~|res;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int FUNC_W = 6
) (
  input  logic [1:0]        mode,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  output logic [W-1:0]      result,
  output logic              zero,
  output logic              ovf
);

  alu_op_e op_sel;
  logic    unused_fn_hi;

  assign unused_fn_hi = ^func_code[FUNC_W-1:SEL_W];

  alu_op_decoder u_dec (
    .mode   (mode),
    .fn_low (func_code[SEL_W-1:0]),
    .op     (op_sel)
  );

  alu_datapath #(.W(W)) u_dp (
    .a        (opnd_a),
    .b        (opnd_b),
    .op       (op_sel),
    .res      (result),
    .res_zero (zero)
  );

  assign ovf = 1'b0;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int W      = 32,
  parameter int FUNC_W = 6
) (
  input logic [1:0]        mode,
  input logic [FUNC_W-1:0] func_code,
  input logic [W-1:0]      opnd_a,
  input logic [W-1:0]      opnd_b,
  input logic [W-1:0]      result,
  input logic              zero
);

  always_comb begin
    if (mode == 2'b00)
      assert_addr_add_R1: assert (result == opnd_a + opnd_b);
    if (mode == 2'b01)
      assert_cmp_sub_R2: assert (result == opnd_a - opnd_b);
    if (mode == 2'b01)
      assert_cmp_zero_R7: assert (zero == (opnd_a == opnd_b));
    if (mode == 2'b11 && func_code[3:0] != 4'b0010 && func_code[3:0] != 4'b1010)
      assert_reglim_default_R4: assert (result == opnd_a + opnd_b);
    if (mode[1] && func_code[3:0] == 4'b1010)
      assert_slt_bool_R6: assert (result[W-1:1] == '0);
  end

endmodule

bind alu_unit alu_unit_chk #(.W(W), .FUNC_W(FUNC_W)) u_chk (
  .mode      (mode),
  .func_code (func_code),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .zero      (zero)
);

// File: tb/tb_alu_unit.sv
module tb_alu_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [5:0]  func_code = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        zero;
  logic        ovf;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_unit dut (
    .mode(mode), .func_code(func_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .zero(zero), .ovf(ovf)
  );

  function automatic logic [31:0] model(input logic [1:0] m, input logic [5:0] f,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [3:0] lo;
    logic [31:0] slt;
    lo  = f[3:0];
    slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    case (m)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: case (lo)
               4'b0010: return a - b;
               4'b0100: return a & b;
               4'b0101: return a | b;
               4'b1010: return slt;
               default: return a + b;
             endcase
      default: case (lo)
               4'b0010: return a - b;
               4'b1010: return slt;
               default: return a + b;
             endcase
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (mode=%b func=%b a=%h b=%h)",
               tag, got, exp, mode, func_code, opnd_a, opnd_b);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] m, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    @(posedge clk);
    mode = m; func_code = f; opnd_a = a; opnd_b = b;
    @(negedge clk);
    e = model(m, f, a, b);
    check(tag, result, e);
    check("R7 zero", {31'd0, zero}, {31'd0, (e == 32'd0)});
    check("R8 ovf", {31'd0, ovf}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: 0 + 0
    @(negedge clk);
    check("R1 idle result", result, 32'd0);
    check("R7 idle zero", {31'd0, zero}, 32'd1);

    // R1 R2 R3 R4 R5 R9: every mode against every function code
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 64; f++)
        apply("R3/R4/R5/R9 sweep", 2'(m), 6'(f), $urandom, $urandom);

    // R9: upper function bits ignored
    apply("R9 hi bits and", 2'b10, 6'b110100, 32'hF0F0_1234, 32'h0FF0_FFFF);
    apply("R9 hi bits or",  2'b10, 6'b010101, 32'hF000_0000, 32'h0000_000F);

    // R6: signed compare corners
    apply("R6 neg<pos",    2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1);
    apply("R6 pos>neg",    2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF);
    apply("R6 min<max",    2'b11, 6'b001010, 32'h8000_0000, 32'h7FFF_FFFF);
    apply("R6 max>min",    2'b11, 6'b001010, 32'h7FFF_FFFF, 32'h8000_0000);
    apply("R6 equal",      2'b10, 6'b001010, 32'h1234_5678, 32'h1234_5678);

    // R4: restricted mode refuses AND and OR
    apply("R4 and refused", 2'b11, 6'b000100, 32'hFFFF_0000, 32'h00FF_FF00);
    apply("R4 or refused",  2'b11, 6'b000101, 32'h0000_0001, 32'h0000_0001);

    // R1 R7: wrap to zero
    apply("R1 wrap zero", 2'b00, 6'b000000, 32'hFFFF_FFFF, 32'd1);
    // R2 R7: branch equality
    apply("R2 equal",     2'b01, 6'b111111, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply("R2 borrow",    2'b01, 6'b000000, 32'd0, 32'd1);

    // random mix
    for (int i = 0; i < 3000; i++)
      apply("R1-mix random", 2'($urandom), 6'($urandom), $urandom, $urandom);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule